// File: doc/BRIEF.md
# Cascadable Four-Lane Column Driver Core

This block is the digital core of a dot-matrix display column driver with a line of 80 outputs. Display data arrives four bits at a time on a slow shift clock. The block captures each group into a line buffer. A direction select decides where each group lands, so the line fills either from the first output upward or from the last output downward. When a line strobe falls, the full buffer is copied into a held register, and filling starts over for the next line.

Several cores can be chained. Each core accepts data only while its chain input is low. It drives its chain output low once its own line is full. The next core in the chain then takes the following groups on the same shared data and clock wires.

Each output produces a 2-bit code that selects one of four bias rails. The code is formed from the held bit, a frame-polarity input and an active-low blanking input. The shift clock and the line strobe are asynchronous to the system clock. They pass through synchronisers, and only their falling edges act.

Top module: `segdrv_core`

## Requirements
- R1: The active-low reset clears the line buffer, the held register and the fill position, and sets the chain output high. After reset, with blanking high and frame polarity low, every output code is 01.
- R2: With the direction select low, the k-th accepted falling edge of the shift clock (k counted from 0) writes data lane j to output 4k+j (outputs numbered 0 to 79).
- R3: With the direction select high, the k-th accepted falling edge writes data lane j to output 79-4k-j.
- R4: While the chain input is high, falling edges of the shift clock are ignored: the buffer is not written and the fill position does not advance.
- R5: The chain output stays high through the first 19 accepted groups of a line and goes low after the 20th. While it is low, further shift-clock edges are ignored until the next line strobe.
- R6: A falling edge of the line strobe copies the line buffer into the held register, returns the fill position to the first group and drives the chain output high. This applies even when the line is only partly filled.
- R7: When blanking is high, an output's code is 00 for held bit 1 with frame polarity 0, 01 for bit 0 with polarity 0, 10 for bit 0 with polarity 1, and 11 for bit 1 with polarity 1. The rails in code order are highest, upper-middle, lower-middle and lowest.
- R8: While blanking is low, every output code is 00, regardless of the held data or the frame polarity.
- R9: The output codes do not change on shift-clock edges. Only a line strobe changes the held data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Data shift clock, acts on its falling edge |
| line_strobe | input | 1 | Line transfer strobe, acts on its falling edge |
| chain_in_n | input | 1 | Active-low chain enable from the previous core |
| chain_out_n | output | 1 | Active-low chain enable to the next core; low once the line is full |
| dir_rev | input | 1 | Fill direction: 0 fills upward, 1 fills downward |
| data_in | input | 4 | Four display bits per shift-clock edge |
| frame_pol | input | 1 | Frame-inversion polarity |
| blank_n | input | 1 | Active-low blanking; forces the highest rail on all outputs |
| level_code | output | 160 | Two bits per output selecting the bias rail, output i at bits 2i+1:2i |

## Verification
The hardest state to reach from the ports is a full line with extra shift-clock edges arriving before the strobe. A 21st group with a distinctive pattern is pushed after the chain output has dropped. The strobe that follows must show the first 20 groups unchanged. The chain input is also held high across a whole run of edges, and a strobe then shows that the previous line's buffer is still intact. A partial line followed by a strobe and one more group shows that the position really returned to the start.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;

  // Bias rails, ordered from the most positive to the most negative.
  typedef enum logic [1:0] {
    LVL_TOP    = 2'b00,
    LVL_MID_HI = 2'b01,
    LVL_MID_LO = 2'b10,
    LVL_BOT    = 2'b11
  } lvl_e;

  function automatic lvl_e pick_level(input logic held_bit,
                                      input logic frame,
                                      input logic blank_n);
    lvl_e res;
    if (!blank_n)                res = LVL_TOP;
    else if (!frame && held_bit) res = LVL_TOP;
    else if (!frame)             res = LVL_MID_HI;
    else if (!held_bit)          res = LVL_MID_LO;
    else                         res = LVL_BOT;
    return res;
  endfunction

endpackage

// File: rtl/segdrv_fall_det.sv
module segdrv_fall_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall_pulse
);

  localparam int TOTAL = SYNC_STAGES + 1;

  logic [TOTAL-1:0] sync_q;
  logic [TOTAL-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[TOTAL-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  // The oldest stage is still high while the newer one has gone low.
  assign fall_pulse = sync_q[TOTAL-1] & ~sync_q[TOTAL-2];

endmodule

// File: rtl/segdrv_line_fill.sv
module segdrv_line_fill #(
  parameter int LINE_W = 80,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_fall,
  input  logic              load_fall,
  input  logic              en_in_n,
  input  logic              dir_rev,
  input  logic [LANES-1:0]  data_in,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] held_q,
  output logic              full_q
);

  localparam int STEPS = LINE_W / LANES;
  localparam int PTR_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int IDX_W = (LINE_W > 1) ? $clog2(LINE_W) : 1;

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [LINE_W-1:0] line_d, held_d;
  logic              full_d;
  logic              accept;
  logic [IDX_W-1:0]  base;
  logic [IDX_W-1:0]  fwd;

  always_comb begin
    line_d = line_q;
    held_d = held_q;
    ptr_d  = ptr_q;
    full_d = full_q;
    fwd    = '0;
    accept = shift_fall & ~en_in_n & ~full_q & ~load_fall;
    base   = IDX_W'(ptr_q) * IDX_W'(LANES);
    if (load_fall) begin
      held_d = line_q;
      ptr_d  = '0;
      full_d = 1'b0;
    end else if (accept) begin
      for (int j = 0; j < LANES; j++) begin
        fwd = base + IDX_W'(j);
        if (dir_rev) line_d[IDX_W'(LINE_W-1) - fwd] = data_in[j];
        else         line_d[fwd]                    = data_in[j];
      end
      if (ptr_q == PTR_W'(STEPS-1)) begin
        ptr_d  = '0;
        full_d = 1'b1;
      end else begin
        ptr_d = ptr_q + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      held_q <= '0;
      ptr_q  <= '0;
      full_q <= 1'b0;
    end else begin
      line_q <= line_d;
      held_q <= held_d;
      ptr_q  <= ptr_d;
      full_q <= full_d;
    end
  end

endmodule

// File: rtl/segdrv_level_enc.sv
module segdrv_level_enc
  import segdrv_pkg::*;
#(
  parameter int LINE_W = 80
) (
  input  logic [LINE_W-1:0]   held_q,
  input  logic                frame_pol,
  input  logic                blank_n,
  output logic [2*LINE_W-1:0] level_code
);

  for (genvar i = 0; i < LINE_W; i++) begin : g_out
    lvl_e lvl;
    assign lvl = pick_level(held_q[i], frame_pol, blank_n);
    assign level_code[2*i +: 2] = lvl;
  end

endmodule

// File: rtl/segdrv_core.sv
module segdrv_core #(
  parameter int LINE_W = 80,
  parameter int LANES  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_clk,
  input  logic                line_strobe,
  input  logic                chain_in_n,
  output logic                chain_out_n,
  input  logic                dir_rev,
  input  logic [LANES-1:0]    data_in,
  input  logic                frame_pol,
  input  logic                blank_n,
  output logic [2*LINE_W-1:0] level_code
);

  logic              shift_fall;
  logic              load_fall;
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] held_q;
  logic              full_q;

  segdrv_fall_det #(.SYNC_STAGES(2)) u_shift_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (shift_clk),
    .fall_pulse (shift_fall)
  );

  segdrv_fall_det #(.SYNC_STAGES(2)) u_load_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (line_strobe),
    .fall_pulse (load_fall)
  );

  segdrv_line_fill #(.LINE_W(LINE_W), .LANES(LANES)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_fall (shift_fall),
    .load_fall  (load_fall),
    .en_in_n    (chain_in_n),
    .dir_rev    (dir_rev),
    .data_in    (data_in),
    .line_q     (line_q),
    .held_q     (held_q),
    .full_q     (full_q)
  );

  segdrv_level_enc #(.LINE_W(LINE_W)) u_enc (
    .held_q     (held_q),
    .frame_pol  (frame_pol),
    .blank_n    (blank_n),
    .level_code (level_code)
  );

  assign chain_out_n = ~full_q;

endmodule

// File: rtl/segdrv_core_chk.sv
module segdrv_core_chk #(
  parameter int LINE_W = 80
) (
  input logic                clk,
  input logic                rst_n,
  input logic                load_fall,
  input logic                chain_in_n,
  input logic                chain_out_n,
  input logic                blank_n,
  input logic                frame_pol,
  input logic [LINE_W-1:0]   line_q,
  input logic [LINE_W-1:0]   held_q,
  input logic [2*LINE_W-1:0] level_code
);

  logic [2*LINE_W-1:0] odd_mask;
  always_comb begin
    odd_mask = '0;
    for (int i = 0; i < LINE_W; i++) odd_mask[2*i+1] = 1'b1;
  end

  assert_gate_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chain_in_n |=> $stable(line_q));

  assert_full_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_out_n && !load_fall) |=> !chain_out_n);

  assert_load_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall |=> chain_out_n);

  assert_polarity_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !frame_pol) |-> ((level_code & odd_mask) == '0));

  assert_polarity_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && frame_pol) |-> ((level_code & odd_mask) == odd_mask));

  assert_blank_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (level_code == '0));

  assert_held_on_load_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fall |=> $stable(held_q));

endmodule

bind segdrv_core segdrv_core_chk #(.LINE_W(LINE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_fall   (load_fall),
  .chain_in_n  (chain_in_n),
  .chain_out_n (chain_out_n),
  .blank_n     (blank_n),
  .frame_pol   (frame_pol),
  .line_q      (line_q),
  .held_q      (held_q),
  .level_code  (level_code)
);

// File: tb/segdrv_core_bench.sv
module segdrv_core_bench;

  localparam int LW = 80;
  localparam int LN = 4;
  localparam int ST = LW / LN;

  logic clk = 1'b0;
  logic rst_n, shift_clk, line_strobe, chain_in_n, dir_rev, frame_pol, blank_n;
  logic [LN-1:0]   data_in;
  logic            chain_out_n;
  logic [2*LW-1:0] level_code;

  always #4 clk = ~clk;

  segdrv_core u_segdrv_core (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .line_strobe(line_strobe),
    .chain_in_n(chain_in_n), .chain_out_n(chain_out_n), .dir_rev(dir_rev),
    .data_in(data_in), .frame_pol(frame_pol), .blank_n(blank_n),
    .level_code(level_code)
  );

  int checks = 0;
  int errors = 0;

  // Reference model, built from the requirements.
  logic [LW-1:0] m_line = '0;
  logic [LW-1:0] m_held = '0;
  int  m_ptr  = 0;
  bit  m_full = 1'b0;

  logic [2*LW-1:0] exp_q[$];
  string           tag_q[$];
  event            sample_ev;

  function automatic logic [1:0] exp_code(logic b, logic f, logic bl_n);
    if (!bl_n) return 2'b00;
    return {f, ~(b ^ f)};
  endfunction

  function automatic logic [2*LW-1:0] build_exp();
    logic [2*LW-1:0] v;
    for (int i = 0; i < LW; i++) v[2*i +: 2] = exp_code(m_held[i], frame_pol, blank_n);
    return v;
  endfunction

  task automatic push_now(string tag);
    exp_q.push_back(build_exp());
    tag_q.push_back(tag);
    -> sample_ev;
    @(negedge clk);
  endtask

  task automatic shift_one(logic [LN-1:0] nib);
    @(negedge clk);
    data_in   = nib;
    shift_clk = 1'b1;
    repeat (5) @(negedge clk);
    shift_clk = 1'b0;
    repeat (5) @(negedge clk);
    if (!chain_in_n && !m_full) begin
      for (int j = 0; j < LN; j++) begin
        if (dir_rev) m_line[LW-1-(m_ptr*LN+j)] = nib[j];
        else         m_line[m_ptr*LN+j]        = nib[j];
      end
      if (m_ptr == ST-1) begin m_ptr = 0; m_full = 1'b1; end
      else m_ptr++;
    end
  endtask

  task automatic strobe(string tag);
    @(negedge clk);
    line_strobe = 1'b1;
    repeat (5) @(negedge clk);
    line_strobe = 1'b0;
    repeat (6) @(negedge clk);
    m_held = m_line;
    m_ptr  = 0;
    m_full = 1'b0;
    push_now(tag);
  endtask

  task automatic check_chain(logic exp, string tag);
    checks++;
    if (chain_out_n !== exp) begin
      errors++;
      $display("FAIL %s chain_out_n actual %b expected %b", tag, chain_out_n, exp);
    end
  endtask

  // Monitor: pops each expected vector and compares it with the outputs.
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        logic [2*LW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (level_code !== e) begin
          errors++;
          $display("FAIL %s level_code actual %h expected %h", t, level_code, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; shift_clk = 1'b0; line_strobe = 1'b0; chain_in_n = 1'b0;
    dir_rev = 1'b0; frame_pol = 1'b0; blank_n = 1'b1; data_in = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    push_now("R1");
    check_chain(1'b1, "R1");

    // Forward line, with the full-line flag observed around the 20th group.
    for (int k = 0; k < ST - 1; k++) shift_one(LN'((k * 7 + 3) % 16));
    check_chain(1'b1, "R5");
    shift_one(LN'(((ST - 1) * 7 + 3) % 16));
    check_chain(1'b0, "R5");
    push_now("R9");
    shift_one(4'hF);  // extra group after full: must be ignored (R5)
    check_chain(1'b0, "R5");
    strobe("R2");
    check_chain(1'b1, "R6");

    // Reverse line.
    dir_rev = 1'b1;
    for (int k = 0; k < ST; k++) shift_one(LN'((k * 5 + 1) % 16));
    strobe("R3");

    // Level encoding and blanking.
    frame_pol = 1'b1;
    repeat (2) @(negedge clk);
    push_now("R7");
    blank_n = 1'b0;
    repeat (2) @(negedge clk);
    push_now("R8");
    frame_pol = 1'b0;
    repeat (2) @(negedge clk);
    push_now("R8");
    blank_n = 1'b1;
    repeat (2) @(negedge clk);
    push_now("R7");

    // Chain input high: groups ignored, buffer keeps the reverse line.
    chain_in_n = 1'b1;
    dir_rev    = 1'b0;
    for (int k = 0; k < 6; k++) shift_one(LN'(k + 8));
    check_chain(1'b1, "R4");
    strobe("R4");

    // Partial line, strobe, then one group must land at the start again.
    chain_in_n = 1'b0;
    for (int k = 0; k < 3; k++) shift_one(4'hA);
    strobe("R6");
    shift_one(4'h5);
    strobe("R6");
    frame_pol = 1'b1;
    repeat (2) @(negedge clk);
    push_now("R7");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule